// File: doc/BRIEF.md
# Paged Memory Map Bank Decoder

This block turns a 24-bit access address into chip selects for a paged memory map. The top 8 address bits pick one of 256 pages of 64K words. Page 0 holds on-chip storage: two 24-bit RAM blocks, one 16-bit data RAM and a reserved gap. Page 255 holds a small boot ROM at its base, and the rest of that page is unused. Every page in between belongs to one of four external banks. Each bank has its own select line, and the bank boundaries sit at programmable start pages.

A second, separate I/O space uses 1K-word pages. The low I/O pages are kept on-chip. The remaining pages drive a dedicated I/O select.

An access starts with a one-cycle start strobe that carries the address, a read/write flag and a space flag. For an external target, the block loads that target's read or write wait count into a counter. It holds the select while the counter runs down, then raises a one-cycle ready. On-chip, reserved and unused targets complete in the first cycle.

Top module: `paged_bank_decoder`

## Requirements
- R1: A memory access to page 0 drives int_sel one-hot and no external select, with ready in the first select cycle. Bit 0 covers offsets 0x0000–0x3FFF, bit 1 covers 0x4000–0x7FFF and bit 2 covers 0x8000–0x9FFF.
- R2: Address 0xFF0000–0xFF0FFF drives int_sel bit 3. Page 0 offsets 0xA000–0xFFFF and page 255 offsets from 0x1000 up drive no select at all, and ready is high in the first cycle.
- R3: After reset, pages 1–63 select bank 0 (bank_cs bit 0), 64–127 bank 1, 128–191 bank 2 and 192–254 bank 3. A page selects bank i when it is at least bank i's start page and below bank i+1's start page.
- R4: A pulse on cfg_bnd_we loads the start pages of banks 1, 2 and 3 from cfg_bnd_pages bits [7:0], [15:8] and [23:16]. Bank 0 always starts at page 1. The new map applies from the next access.
- R5: A boundary load is ignored, and the previous map kept, unless 1 < bank1 < bank2 < bank3 < 255.
- R6: The wait count W is taken from the 4-bit field [4i+3:4i] of cfg_rd_wait for a read or of cfg_wr_wait for a write. Index i is 0–3 for the banks and 4 for the I/O space. Ready rises W cycles after the first select cycle. The select is held unchanged through the ready cycle and released on the next cycle.
- R7: An access with acc_io high uses acc_addr[17:10] as the I/O page. Pages 0–31 drive no select and give ready in the first cycle. Pages 32–255 drive io_cs.
- R8: cfg_sel_pol bit i (bits 0–3 for the banks, bit 4 for the I/O space) sets that select's polarity. 0 means active-low and idle high; 1 means active-high and idle low.
- R9: At most one select (internal, bank or I/O) is active in any cycle, and ready is never high for two consecutive cycles.
- R10: An acc_start that arrives while an access is in progress has no effect on the selects or on the ready timing of that access.
- R11: Synchronous reset clears ready and all selects and restores the boundary split of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | One-cycle strobe that begins an access |
| acc_io | input | 1 | 1 = I/O space, 0 = memory space |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 24 | Access address |
| cfg_bnd_we | input | 1 | Load strobe for the bank start pages |
| cfg_bnd_pages | input | 24 | Start pages of banks 1..3 |
| cfg_rd_wait | input | 20 | Read wait counts, 4 bits per external space |
| cfg_wr_wait | input | 20 | Write wait counts, 4 bits per external space |
| cfg_sel_pol | input | 5 | Select polarity per external space |
| int_sel | output | 4 | On-chip region selects, active-high |
| bank_cs | output | 4 | External bank selects |
| io_cs | output | 1 | External I/O select |
| ready | output | 1 | Access completion pulse |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a long external wait. A broken block would either restart its counter or switch to the new target. The bench starts a bank 3 read with four wait cycles. One cycle into the wait, it injects a second start aimed at on-chip RAM. It then checks that the bank 3 select never changes, that no internal select appears, and that ready still comes after exactly four cycles. A second hard case is the rejected boundary load. The bench probes a page whose bank would change if the illegal split had been taken.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  // on-chip regions, index into int_sel
  localparam int RGN_RAM0 = 0;
  localparam int RGN_RAM1 = 1;
  localparam int RGN_DRAM = 2;
  localparam int RGN_BROM = 3;
  localparam int NUM_INT  = 4;

  // last offsets of the on-chip regions inside their page
  localparam int RAM0_LAST = 'h3FFF;
  localparam int RAM1_LAST = 'h7FFF;
  localparam int DRAM_LAST = 'h9FFF;
  localparam int BROM_LAST = 'h0FFF;
endpackage

// File: rtl/pbd_bound_regs.sv
module pbd_bound_regs #(
  parameter int NUM_BANKS = 4,
  parameter int PAGE_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [(NUM_BANKS-1)*PAGE_W-1:0]   cfg_pages,
  output logic [NUM_BANKS-1:0][PAGE_W-1:0]  starts
);
  localparam int PAGES_PER_BANK = (1 << PAGE_W) / NUM_BANKS;

  logic              legal;
  logic [PAGE_W-1:0] prev;

  // the new split must ascend strictly above page 1 and stop below the top page
  always_comb begin
    legal = 1'b1;
    prev  = PAGE_W'(1);
    for (int i = 1; i < NUM_BANKS; i++) begin
      if (cfg_pages[(i-1)*PAGE_W +: PAGE_W] <= prev) legal = 1'b0;
      prev = cfg_pages[(i-1)*PAGE_W +: PAGE_W];
    end
    if (prev == {PAGE_W{1'b1}}) legal = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      starts[0] <= PAGE_W'(1);
      for (int i = 1; i < NUM_BANKS; i++)
        starts[i] <= PAGE_W'(i * PAGES_PER_BANK);
    end else if (cfg_we && legal) begin
      for (int i = 1; i < NUM_BANKS; i++)
        starts[i] <= cfg_pages[(i-1)*PAGE_W +: PAGE_W];
    end
  end
endmodule

// File: rtl/pbd_addr_decode.sv
module pbd_addr_decode
  import pbd_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int PAGE_W          = 8,
  parameter int NUM_BANKS       = 4,
  parameter int IO_OFS_W        = 10,
  parameter int IO_PAGE_W       = 8,
  parameter int IO_ONCHIP_PAGES = 32
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              io,
  input  logic [NUM_BANKS-1:0][PAGE_W-1:0]  starts,
  output logic [NUM_INT-1:0]                int_hit,
  output logic [NUM_BANKS:0]                ext_hit
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0]    page;
  logic [OFS_W-1:0]     ofs;
  logic [IO_PAGE_W-1:0] io_page;
  logic [NUM_BANKS-1:0] in_bank;

  assign page    = addr[ADDR_W-1 -: PAGE_W];
  assign ofs     = addr[OFS_W-1:0];
  assign io_page = addr[IO_OFS_W +: IO_PAGE_W];

  // range test per bank: at or above its start, below the next start
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    if (i == NUM_BANKS - 1) begin : g_last
      assign in_bank[i] = (page >= starts[i]);
    end else begin : g_mid
      assign in_bank[i] = (page >= starts[i]) && (page < starts[i+1]);
    end
  end

  always_comb begin
    int_hit = '0;
    ext_hit = '0;
    if (io) begin
      ext_hit[NUM_BANKS] = (io_page >= IO_PAGE_W'(IO_ONCHIP_PAGES));
    end else if (page == '0) begin
      if (ofs <= OFS_W'(RAM0_LAST))      int_hit[RGN_RAM0] = 1'b1;
      else if (ofs <= OFS_W'(RAM1_LAST)) int_hit[RGN_RAM1] = 1'b1;
      else if (ofs <= OFS_W'(DRAM_LAST)) int_hit[RGN_DRAM] = 1'b1;
    end else if (page == {PAGE_W{1'b1}}) begin
      if (ofs <= OFS_W'(BROM_LAST))      int_hit[RGN_BROM] = 1'b1;
    end else begin
      ext_hit[NUM_BANKS-1:0] = in_bank;
    end
  end
endmodule

// File: rtl/pbd_wait_ctrl.sv
module pbd_wait_ctrl #(
  parameter int NUM_EXT = 5,
  parameter int NUM_INT = 4,
  parameter int WAIT_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        write,
  input  logic [NUM_INT-1:0]          int_hit,
  input  logic [NUM_EXT-1:0]          ext_hit,
  input  logic [NUM_EXT*WAIT_W-1:0]   rd_wait,
  input  logic [NUM_EXT*WAIT_W-1:0]   wr_wait,
  output logic [NUM_INT-1:0]          int_q,
  output logic [NUM_EXT-1:0]          ext_q,
  output logic                        rdy_q
);
  logic              busy;
  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] wsel;

  // wait count of the hit space; zero for on-chip or empty targets
  always_comb begin
    wsel = '0;
    for (int i = 0; i < NUM_EXT; i++)
      if (ext_hit[i])
        wsel = write ? wr_wait[i*WAIT_W +: WAIT_W] : rd_wait[i*WAIT_W +: WAIT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      rdy_q <= 1'b0;
      cnt   <= '0;
      int_q <= '0;
      ext_q <= '0;
    end else if (busy) begin
      if (rdy_q) begin
        busy  <= 1'b0;
        rdy_q <= 1'b0;
        int_q <= '0;
        ext_q <= '0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == WAIT_W'(1)) rdy_q <= 1'b1;
      end
    end else if (start) begin
      busy  <= 1'b1;
      int_q <= int_hit;
      ext_q <= ext_hit;
      cnt   <= wsel;
      rdy_q <= (wsel == '0);
    end
  end
endmodule

// File: rtl/paged_bank_decoder.sv
module paged_bank_decoder
  import pbd_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int PAGE_W          = 8,
  parameter int NUM_BANKS       = 4,
  parameter int WAIT_W          = 4,
  parameter int IO_OFS_W        = 10,
  parameter int IO_PAGE_W       = 8,
  parameter int IO_ONCHIP_PAGES = 32,
  localparam int NUM_EXT        = NUM_BANKS + 1,
  localparam int BND_W          = (NUM_BANKS - 1) * PAGE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_start,
  input  logic                       acc_io,
  input  logic                       acc_write,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic                       cfg_bnd_we,
  input  logic [BND_W-1:0]           cfg_bnd_pages,
  input  logic [NUM_EXT*WAIT_W-1:0]  cfg_rd_wait,
  input  logic [NUM_EXT*WAIT_W-1:0]  cfg_wr_wait,
  input  logic [NUM_EXT-1:0]         cfg_sel_pol,
  output logic [NUM_INT-1:0]         int_sel,
  output logic [NUM_BANKS-1:0]       bank_cs,
  output logic                       io_cs,
  output logic                       ready
);
  logic [NUM_BANKS-1:0][PAGE_W-1:0] starts;
  logic [NUM_INT-1:0]               int_hit;
  logic [NUM_EXT-1:0]               ext_hit;
  logic [NUM_INT-1:0]               int_q;
  logic [NUM_EXT-1:0]               ext_q;

  pbd_bound_regs #(.NUM_BANKS(NUM_BANKS), .PAGE_W(PAGE_W)) i_bounds (
    .clk(clk), .rst(rst), .cfg_we(cfg_bnd_we), .cfg_pages(cfg_bnd_pages),
    .starts(starts)
  );

  pbd_addr_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NUM_BANKS(NUM_BANKS),
    .IO_OFS_W(IO_OFS_W), .IO_PAGE_W(IO_PAGE_W), .IO_ONCHIP_PAGES(IO_ONCHIP_PAGES)
  ) i_decode (
    .addr(acc_addr), .io(acc_io), .starts(starts),
    .int_hit(int_hit), .ext_hit(ext_hit)
  );

  pbd_wait_ctrl #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .WAIT_W(WAIT_W)) i_wait (
    .clk(clk), .rst(rst), .start(acc_start), .write(acc_write),
    .int_hit(int_hit), .ext_hit(ext_hit),
    .rd_wait(cfg_rd_wait), .wr_wait(cfg_wr_wait),
    .int_q(int_q), .ext_q(ext_q), .rdy_q(ready)
  );

  // polarity bit 0 = active-low, 1 = active-high
  assign int_sel = int_q;
  assign bank_cs = ext_q[NUM_BANKS-1:0] ~^ cfg_sel_pol[NUM_BANKS-1:0];
  assign io_cs   = ext_q[NUM_BANKS] ~^ cfg_sel_pol[NUM_BANKS];
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_INT   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_INT-1:0]   int_sel,
  input logic [NUM_BANKS-1:0] bank_cs,
  input logic                 io_cs,
  input logic [NUM_BANKS:0]   cfg_sel_pol,
  input logic                 ready
);
  logic [NUM_BANKS:0] ext_act;
  assign ext_act = {io_cs, bank_cs} ~^ cfg_sel_pol;

  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({int_sel, ext_act}));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((ext_act != '0) && !ready) |=> (ext_act == $past(ext_act)));

  // R6
  sel_release_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ((ext_act == '0) && (int_sel == '0)));

  // R1
  int_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (int_sel != '0) |-> ready);

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ready && (int_sel == '0) && (ext_act == '0)));
endmodule

bind paged_bank_decoder pbd_checker #(.NUM_BANKS(NUM_BANKS), .NUM_INT(pbd_pkg::NUM_INT)) i_chk (
  .clk(clk), .rst(rst), .int_sel(int_sel), .bank_cs(bank_cs), .io_cs(io_cs),
  .cfg_sel_pol(cfg_sel_pol), .ready(ready)
);

// File: tb/test_paged_bank_decoder.sv
module test_paged_bank_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_start = 1'b0, acc_io = 1'b0, acc_write = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        cfg_bnd_we = 1'b0;
  logic [23:0] cfg_bnd_pages = '0;
  // read waits: bank0..3 = 1,2,3,4, io = 5 ; write waits: 0,3,6,9, io = 7
  logic [19:0] cfg_rd_wait = {4'd5, 4'd4, 4'd3, 4'd2, 4'd1};
  logic [19:0] cfg_wr_wait = {4'd7, 4'd9, 4'd6, 4'd3, 4'd0};
  logic [4:0]  cfg_sel_pol = '0;
  logic [3:0]  int_sel;
  logic [3:0]  bank_cs;
  logic        io_cs;
  logic        ready;

  int checks = 0, fails = 0, ticks = 0;
  bit done = 1'b0;

  paged_bank_decoder i_paged_bank_decoder (
    .clk(clk), .rst(rst), .acc_start(acc_start), .acc_io(acc_io),
    .acc_write(acc_write), .acc_addr(acc_addr), .cfg_bnd_we(cfg_bnd_we),
    .cfg_bnd_pages(cfg_bnd_pages), .cfg_rd_wait(cfg_rd_wait),
    .cfg_wr_wait(cfg_wr_wait), .cfg_sel_pol(cfg_sel_pol),
    .int_sel(int_sel), .bank_cs(bank_cs), .io_cs(io_cs), .ready(ready)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", ticks);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // {req[4], io, wr, addr[24], int[4], ext[5], wait[4]}
  localparam int NV = 23;
  localparam logic [42:0] VECS [NV] = '{
    {4'd1, 1'b0, 1'b0, 24'h000000, 4'b0001, 5'b00000, 4'd0},  // R1
    {4'd1, 1'b0, 1'b1, 24'h003FFF, 4'b0001, 5'b00000, 4'd0},  // R1
    {4'd1, 1'b0, 1'b0, 24'h004000, 4'b0010, 5'b00000, 4'd0},  // R1
    {4'd1, 1'b0, 1'b0, 24'h007FFF, 4'b0010, 5'b00000, 4'd0},  // R1
    {4'd1, 1'b0, 1'b1, 24'h008000, 4'b0100, 5'b00000, 4'd0},  // R1
    {4'd1, 1'b0, 1'b0, 24'h009FFF, 4'b0100, 5'b00000, 4'd0},  // R1
    {4'd2, 1'b0, 1'b0, 24'h00A000, 4'b0000, 5'b00000, 4'd0},  // R2
    {4'd2, 1'b0, 1'b0, 24'h00FFFF, 4'b0000, 5'b00000, 4'd0},  // R2
    {4'd2, 1'b0, 1'b0, 24'hFF0000, 4'b1000, 5'b00000, 4'd0},  // R2
    {4'd2, 1'b0, 1'b0, 24'hFF0FFF, 4'b1000, 5'b00000, 4'd0},  // R2
    {4'd2, 1'b0, 1'b0, 24'hFF1000, 4'b0000, 5'b00000, 4'd0},  // R2
    {4'd3, 1'b0, 1'b0, 24'h010000, 4'b0000, 5'b00001, 4'd1},  // R3 R6
    {4'd3, 1'b0, 1'b1, 24'h3FFFFF, 4'b0000, 5'b00001, 4'd0},  // R3 R6
    {4'd3, 1'b0, 1'b0, 24'h400000, 4'b0000, 5'b00010, 4'd2},  // R3
    {4'd3, 1'b0, 1'b1, 24'h7F1234, 4'b0000, 5'b00010, 4'd3},  // R3
    {4'd3, 1'b0, 1'b0, 24'h800000, 4'b0000, 5'b00100, 4'd3},  // R3
    {4'd6, 1'b0, 1'b1, 24'hBFFFFF, 4'b0000, 5'b00100, 4'd6},  // R6
    {4'd3, 1'b0, 1'b0, 24'hC00000, 4'b0000, 5'b01000, 4'd4},  // R3
    {4'd6, 1'b0, 1'b1, 24'hFEFFFF, 4'b0000, 5'b01000, 4'd9},  // R6
    {4'd7, 1'b1, 1'b0, 24'h007FFF, 4'b0000, 5'b00000, 4'd0},  // R7
    {4'd7, 1'b1, 1'b0, 24'h008000, 4'b0000, 5'b10000, 4'd5},  // R7
    {4'd7, 1'b1, 1'b1, 24'h03FFFF, 4'b0000, 5'b10000, 4'd7},  // R7
    {4'd7, 1'b1, 1'b0, 24'h000000, 4'b0000, 5'b00000, 4'd0}   // R7
  };

  function automatic logic [4:0] ext_view();
    return {io_cs, bank_cs} ~^ cfg_sel_pol;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic access(input bit io, input bit wr, input logic [23:0] a, input int intr,
                        output logic [3:0] i0, output logic [4:0] e0,
                        output int cyc, output bit held, output bit rel);
    @(negedge clk);
    acc_start = 1'b1; acc_io = io; acc_write = wr; acc_addr = a;
    @(negedge clk);
    acc_start = 1'b0;
    i0 = int_sel; e0 = ext_view(); cyc = 0; held = 1'b1;
    while (!ready && cyc < 40) begin
      if (cyc == intr) begin
        acc_start = 1'b1; acc_io = 1'b0; acc_write = 1'b0; acc_addr = 24'h000000;
      end
      @(negedge clk);
      acc_start = 1'b0;
      cyc++;
      if (int_sel != i0 || ext_view() != e0) held = 1'b0;
    end
    @(negedge clk);
    rel = (int_sel == '0) && (ext_view() == '0) && !ready;
  endtask

  task automatic run_exp(input bit io, input bit wr, input logic [23:0] a,
                         input logic [3:0] ei, input logic [4:0] ee, input int ew,
                         input string tag, input int intr);
    logic [3:0] i0; logic [4:0] e0; int cyc; bit held, rel;
    access(io, wr, a, intr, i0, e0, cyc, held, rel);
    check(i0 == ei && e0 == ee, tag, "select", {i0, e0}, {ei, ee});
    check(cyc == ew, tag, "wait cycles", cyc, ew);
    check(held && rel, tag, "hold/release", {held, rel}, 2'b11);
  endtask

  task automatic load_bounds(input logic [23:0] v);
    @(negedge clk);
    cfg_bnd_we = 1'b1; cfg_bnd_pages = v;
    @(negedge clk);
    cfg_bnd_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 idle outputs after reset
    check(bank_cs == 4'hF && io_cs && int_sel == '0 && !ready, "R11", "reset idle",
          {bank_cs, io_cs, int_sel, ready}, {4'hF, 1'b1, 4'h0, 1'b0});

    for (int k = 0; k < NV; k++)
      run_exp(VECS[k][38], VECS[k][37], VECS[k][36:13], VECS[k][12:9], VECS[k][8:4],
              int'(VECS[k][3:0]), $sformatf("R%0d", VECS[k][42:39]), -1);

    // R4 new split: bank1 from 10, bank2 from 100, bank3 from 200
    load_bounds(24'hC8_64_0A);
    run_exp(1'b0, 1'b0, 24'h090000, 4'b0, 5'b00001, 1, "R4", -1);
    run_exp(1'b0, 1'b0, 24'h0A0000, 4'b0, 5'b00010, 2, "R4", -1);
    run_exp(1'b0, 1'b0, 24'h630000, 4'b0, 5'b00010, 2, "R4", -1);
    run_exp(1'b0, 1'b0, 24'h640000, 4'b0, 5'b00100, 3, "R4", -1);
    run_exp(1'b0, 1'b0, 24'hC70000, 4'b0, 5'b00100, 3, "R4", -1);
    run_exp(1'b0, 1'b0, 24'hC80000, 4'b0, 5'b01000, 4, "R4", -1);

    // R5 descending split rejected: page 100 stays in bank 2
    load_bounds(24'h32_64_0A);
    run_exp(1'b0, 1'b0, 24'h640000, 4'b0, 5'b00100, 3, "R5", -1);
    // R5 bank1 start of 1 rejected: page 5 stays in bank 0
    load_bounds(24'hC0_80_01);
    run_exp(1'b0, 1'b0, 24'h050000, 4'b0, 5'b00001, 1, "R5", -1);

    // R11 reset restores the default split (page 10 back in bank 0)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    run_exp(1'b0, 1'b0, 24'h0A0000, 4'b0, 5'b00001, 1, "R11", -1);
    run_exp(1'b0, 1'b0, 24'h400000, 4'b0, 5'b00010, 2, "R11", -1);

    // R8 polarity: bank1 and io active-high
    @(negedge clk); cfg_sel_pol = 5'b10010;
    @(negedge clk);
    check(bank_cs == 4'b1101 && io_cs == 1'b0, "R8", "idle levels",
          {bank_cs, io_cs}, {4'b1101, 1'b0});
    run_exp(1'b0, 1'b0, 24'h400000, 4'b0, 5'b00010, 2, "R8", -1);
    run_exp(1'b1, 1'b0, 24'h008000, 4'b0, 5'b10000, 5, "R8", -1);
    @(negedge clk); cfg_sel_pol = 5'b00000;

    // R10 intruding start one cycle into a bank 3 read
    run_exp(1'b0, 1'b0, 24'hC00000, 4'b0, 5'b01000, 4, "R10", 1);
    // R10 block still accepts a clean access afterwards
    run_exp(1'b0, 1'b0, 24'h000000, 4'b0001, 5'b00000, 0, "R10", -1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule